// File: doc/BRIEF.md
# Dual Timer Interrupt Controller

This block is a small memory-mapped peripheral on a 32-bit register bus. It holds two programmable periodic timers and an interrupt controller for up to `N_SRC` sources. Software writes a rate value to a timer register. The timer then raises its source at half that rate, counted against the system clock frequency `CLK_HZ`. Sources 0 and 1 belong to the timers. Every source can also be raised by a one-cycle pulse on the external `srcIn` vector.

The enable mask and the pending flags are both active low. A mask bit of 0 lets its source through. When an enabled source fires, its pending bit drops to 0 and the processor sees a single-cycle pulse on `irqOut`. Software finds out which source fired by reading the pending register. That read hands back the flags and then sets them all to 1 again, so the read acknowledges the interrupt. Sources fire with no handshake. The timer rate is generated by a phase accumulator, so no divider is needed.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset the mask and the pending flags are all ones. No source is enabled, a pending read returns 0x000000FF (N_SRC = 8), and `irqOut` is low.
- R2: Writing V at byte offset 0x100 programs timer 0, which drives source 0. Writing V at offset 0x104 programs timer 1, which drives source 1. With H = floor(V/2) and H dividing `CLK_HZ`, let P = CLK_HZ/H. The timer fires on the P-th rising edge after the write edge and then on every P-th edge after that.
- R3: A programmed value below 2 (H = 0) stops that timer, and it never fires.
- R4: A write at offset 0x200 loads bits [N_SRC-1:0] of the write data into the enable mask. Bit n = 0 enables source n.
- R5: When source n fires with mask bit n = 0, pending bit n becomes 0 at that edge, and `irqOut` is high for exactly the next cycle.
- R6: When source n fires with mask bit n = 1, the pending flags are unchanged and `irqOut` stays low.
- R7: A read at offset 0x200 returns the pending flags zero-extended to 32 bits, in the same cycle. At that edge every pending bit is set back to 1, except bits of enabled sources that fire in the same cycle, which read 0 afterwards.
- R8: A read at any other offset, including a misaligned one such as 0x202, returns 0xFFFFFFFF. A write at any other offset changes neither the mask, the pending flags nor the timers.
- R9: When several enabled sources fire in the same cycle, all of their pending bits are cleared and `irqOut` is high for one cycle only.
- R10: A high cycle on `srcIn[n]` is one firing of source n. For sources 0 and 1 it is merged with the timer firing.
- R11: Rewriting a rate register restarts that timer's phase from the write edge. The timer does not fire on the write edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the access cycle |
| srcIn | input | N_SRC | External one-cycle source pulses |
| irqOut | output | 1 | Interrupt pulse to the processor |

## Verification
Read data is combinational, so the bench captures it just after it drives the access and before the clock edge that performs the read's side effect. Mask and pending updates land on the access edge. The interrupt pulse appears in the cycle after the enabled firing edge, so the bench samples `irqOut` 1 ns after each edge. For timer runs the bench counts edges from the rate-write edge and expects the pulse exactly after edge P, 2P and so on, with low cycles everywhere else. Random mask, read and pulse traffic is checked every cycle against a bench model of the mask and pending flags.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int unsigned OFF_RATE0 = 32'h100;
  localparam int unsigned OFF_RATE1 = 32'h104;
  localparam int unsigned OFF_MASKPEND = 32'h200;

  typedef struct packed {
    logic wrRate0;
    logic wrRate1;
    logic wrMask;
    logic rdPend;
  } tic_strobe_t;
endpackage

// File: rtl/tic_rate_timer.sv
module tic_rate_timer #(
  parameter int DATA_W = 32,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [DATA_W-1:0] loadVal,
  output logic              fire
);
  localparam int ACC_W = $clog2(CLK_HZ) + 1;
  localparam int SUM_W = ((ACC_W > DATA_W) ? ACC_W : DATA_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(CLK_HZ);

  logic [DATA_W-1:0] half;
  logic [ACC_W-1:0]  acc;
  logic [SUM_W-1:0]  sum;
  logic              running;
  logic              wrap;

  assign sum     = SUM_W'(acc) + SUM_W'(half);
  assign running = (half != '0);
  assign wrap    = running && (sum >= LIMIT);
  assign fire    = wrap && !load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      half <= '0;
      acc  <= '0;
    end else if (load) begin
      half <= loadVal >> 1;
      acc  <= '0;
    end else if (wrap) begin
      acc <= (SUM_W'(half) >= LIMIT) ? '0 : ACC_W'(sum - LIMIT);
    end else if (running) begin
      acc <= ACC_W'(sum);
    end
  end

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !load) |=> $stable(acc) && !fire);

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    SUM_W'(acc) < LIMIT);
endmodule

// File: rtl/tic_control.sv
module tic_control
  import tic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_SRC  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [N_SRC-1:0]  pend,
  output tic_strobe_t       strobe,
  output logic [DATA_W-1:0] busRdata
);
  logic hitRate0, hitRate1, hitMaskPend;

  assign hitRate0    = (busAddr == ADDR_W'(OFF_RATE0));
  assign hitRate1    = (busAddr == ADDR_W'(OFF_RATE1));
  assign hitMaskPend = (busAddr == ADDR_W'(OFF_MASKPEND));

  always_comb begin
    strobe.wrRate0 = busSel && busWr && hitRate0;
    strobe.wrRate1 = busSel && busWr && hitRate1;
    strobe.wrMask  = busSel && busWr && hitMaskPend;
    strobe.rdPend  = busSel && !busWr && hitMaskPend;
  end

  assign busRdata = strobe.rdPend ? DATA_W'(pend) : '1;

  // R8
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/tic_datapath.sv
module tic_datapath
  import tic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_SRC  = 8,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  tic_strobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [N_SRC-1:0]  srcIn,
  output logic [N_SRC-1:0]  pend,
  output logic              irqOut
);
  localparam int N_TMR = 2;

  logic [N_TMR-1:0] tmrLoad;
  logic [N_TMR-1:0] tmrFire;
  logic [N_SRC-1:0] srcFire;
  logic [N_SRC-1:0] enFire;
  logic [N_SRC-1:0] mask;

  assign tmrLoad = {strobe.wrRate1, strobe.wrRate0};

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    tic_rate_timer #(.DATA_W(DATA_W), .CLK_HZ(CLK_HZ)) u_tmr (
      .clk     (clk),
      .rstN    (rstN),
      .load    (tmrLoad[t]),
      .loadVal (busWdata),
      .fire    (tmrFire[t])
    );
  end

  assign srcFire = srcIn | N_SRC'(tmrFire);
  assign enFire  = srcFire & ~mask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask   <= '1;
      pend   <= '1;
      irqOut <= 1'b0;
    end else begin
      if (strobe.wrMask) mask <= busWdata[N_SRC-1:0];
      pend   <= (strobe.rdPend ? '1 : pend) & ~enFire;
      irqOut <= (enFire != '0);
    end
  end

  // R5
  fire_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enFire != '0) |=> (((pend & $past(enFire)) == '0) && irqOut));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((enFire == '0) && !strobe.rdPend) |=> ($stable(pend) && !irqOut));

  // R7
  read_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdPend && (enFire == '0)) |=> (pend == '1));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> (mask == $past(busWdata[N_SRC-1:0])));
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_SRC  = 8,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [N_SRC-1:0]  srcIn,
  output logic              irqOut
);
  tic_strobe_t      strobe;
  logic [N_SRC-1:0] pend;

  tic_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .pend     (pend),
    .strobe   (strobe),
    .busRdata (busRdata)
  );

  tic_datapath #(.DATA_W(DATA_W), .N_SRC(N_SRC), .CLK_HZ(CLK_HZ)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .srcIn    (srcIn),
    .pend     (pend),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/tick_irq_ctrl_test.sv
module tick_irq_ctrl_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int N_SRC  = 8;
  localparam int CLK_HZ = 600;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [N_SRC-1:0]  srcIn = '0;
  logic              irqOut;

  tick_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC), .CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [N_SRC-1:0]  mMask = '1;
  logic [N_SRC-1:0]  mPend = '1;
  logic [DATA_W-1:0] lastRd, expRd;
  logic              lastIrq, expIrq;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N_SRC-1:0] nextPend(input logic [N_SRC-1:0] p, input logic [N_SRC-1:0] m,
                                                input logic [N_SRC-1:0] ev, input logic rd);
    return (rd ? '1 : p) & ~(ev & ~m);
  endfunction

  function automatic logic [DATA_W-1:0] readValue(input logic [ADDR_W-1:0] a, input logic [N_SRC-1:0] p);
    return (a == 12'h200) ? DATA_W'(p) : '1;
  endfunction

  task automatic cycle(input logic s, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [N_SRC-1:0] ev);
    logic rd;
    @(negedge clk);
    busSel = s; busWr = w; busAddr = a; busWdata = d; srcIn = ev;
    #1 lastRd = busRdata;
    rd     = s && !w && (a == 12'h200);
    expRd  = readValue(a, mPend);
    expIrq = |(ev & ~mMask);
    mPend  = nextPend(mPend, mMask, ev, rd);
    if (s && w && a == 12'h200) mMask = d[N_SRC-1:0];
    @(posedge clk);
    #1 lastIrq = irqOut;
    busSel = 1'b0; busWr = 1'b0; srcIn = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    cycle(1'b1, 1'b1, a, d, '0);
  endtask
  task automatic rdReg(input logic [ADDR_W-1:0] a);
    cycle(1'b1, 1'b0, a, '0, '0);
  endtask
  task automatic idle(input logic [N_SRC-1:0] ev);
    cycle(1'b0, 1'b0, '0, '0, ev);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int hits;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 irq after reset", irqOut, 1'b0);
    rdReg(12'h200);
    check("R1 pending reset", lastRd, 32'h000000FF);
    idle(8'hFF);
    check("R1 all masked no irq", lastIrq, 1'b0);

    // R2 R5 timer 0, period 600/100 = 6
    wr(12'h200, 32'hFE);
    wr(12'h100, 32'd200);
    for (int k = 1; k <= 14; k++) begin
      idle('0);
      check($sformatf("R2 R5 timer0 irq at edge %0d", k), lastIrq, (k == 6 || k == 12));
    end
    wr(12'h100, 32'd0);
    hits = 0;
    for (int k = 0; k < 20; k++) begin idle('0); hits += lastIrq; end
    check("R3 stopped timer silent", hits, 0);
    rdReg(12'h200);
    check("R5 pending after timer0", lastRd, 32'hFE);
    rdReg(12'h200);
    check("R7 pending restored", lastRd, 32'hFF);

    // R11 restart phase
    wr(12'h100, 32'd200);
    repeat (3) idle('0);
    wr(12'h100, 32'd200);
    for (int k = 1; k <= 7; k++) begin
      idle('0);
      check($sformatf("R11 restarted timer edge %0d", k), lastIrq, (k == 6));
    end
    wr(12'h100, 32'd1);
    hits = 0;
    for (int k = 0; k < 15; k++) begin idle('0); hits += lastIrq; end
    check("R3 value 1 stops timer", hits, 0);
    rdReg(12'h200);
    check("R11 pending", lastRd, 32'hFE);

    // R2 timer 1, period 600/60 = 10
    wr(12'h200, 32'hFD);
    wr(12'h104, 32'd120);
    for (int k = 1; k <= 10; k++) begin
      idle('0);
      check($sformatf("R2 timer1 irq at edge %0d", k), lastIrq, (k == 10));
    end
    wr(12'h104, 32'd0);
    rdReg(12'h200);
    check("R2 timer1 drives source 1", lastRd, 32'hFD);

    // R6 masked timer
    wr(12'h200, 32'hFF);
    wr(12'h100, 32'd200);
    hits = 0;
    for (int k = 0; k < 14; k++) begin idle('0); hits += lastIrq; end
    check("R6 masked timer no irq", hits, 0);
    wr(12'h100, 32'd0);
    rdReg(12'h200);
    check("R6 masked timer pending", lastRd, 32'hFF);

    // R9 simultaneous external sources
    wr(12'h200, 32'h00);
    idle(8'h0C);
    check("R9 irq on double fire", lastIrq, 1'b1);
    idle('0);
    check("R9 single pulse", lastIrq, 1'b0);
    rdReg(12'h200);
    check("R9 both bits cleared", lastRd, 32'hF3);

    // R10 external pulse on a timer source
    idle(8'h01);
    check("R10 external source 0 irq", lastIrq, 1'b1);
    rdReg(12'h200);
    check("R10 external source 0 pending", lastRd, 32'hFE);

    // R8 undecoded
    rdReg(12'h104);
    check("R8 read 0x104", lastRd, 32'hFFFFFFFF);
    rdReg(12'h000);
    check("R8 read 0x000", lastRd, 32'hFFFFFFFF);
    rdReg(12'h202);
    check("R8 read misaligned", lastRd, 32'hFFFFFFFF);
    wr(12'h200, 32'hFF);
    wr(12'h204, 32'h00);
    idle(8'h10);
    check("R8 write ignored keeps mask", lastIrq, 1'b0);
    rdReg(12'h200);
    check("R8 pending untouched", lastRd, 32'hFF);

    // R7 read racing with a fire, R4 mask bits
    wr(12'h200, 32'h00);
    idle(8'h02);
    cycle(1'b1, 1'b0, 12'h200, '0, 8'h04);
    check("R7 read returns old flags", lastRd, 32'hFD);
    rdReg(12'h200);
    check("R7 same-cycle fire survives read", lastRd, 32'hFB);
    wr(12'h200, 32'hFFFFFF7F);
    idle(8'hC0);
    check("R4 only bit7 enabled irq", lastIrq, 1'b1);
    rdReg(12'h200);
    check("R4 only bit7 pending", lastRd, 32'h7F);

    // Random traffic against the model (R4 R5 R6 R7 R9 R10)
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [N_SRC-1:0] ev;
      op = $urandom % 6;
      ev = (($urandom % 3) == 0) ? N_SRC'($urandom) : '0;
      case (op)
        0: cycle(1'b1, 1'b1, 12'h200, $urandom, ev);
        1, 2: begin
          cycle(1'b1, 1'b0, 12'h200, '0, ev);
          check("R7 random pending read", lastRd, expRd);
        end
        3: begin
          cycle(1'b1, 1'b0, 12'h100, '0, ev);
          check("R8 random undecoded read", lastRd, expRd);
        end
        default: cycle(1'b0, 1'b0, '0, '0, ev);
      endcase
      check("R5 R6 random irq", lastIrq, expIrq);
    end

    finishRun();
  end
endmodule